// File: doc/BRIEF.md
# Execute and Next-PC Unit

This block is the execute step of a simple sequential processor. Each cycle it gets the decoded opcode, the function code and the operand words from the stages around it. From these it produces the ALU result `val_e`, the condition outcome `cond_ok` and the address of the next instruction `new_pc`. Every opcode shares one ALU. That ALU does the arithmetic and logic instructions, the effective-address sums for memory moves, the adjustment of the stack pointer by a fixed step, and a pass-through for conditional moves.

Three condition flags are kept in registers: zero, sign and overflow. They are written at the clock edge, and only by arithmetic or logic instructions that carry a valid function code. Jumps and conditional moves evaluate their condition against the stored flags, which means they see the flags left by the most recent arithmetic instruction. `val_e`, `cond_ok` and `new_pc` are combinational functions of the current inputs and the stored flags. Memory and the register file are outside this block.

Opcode encoding (4 bits): 0 halt, 1 nop, 2 conditional move, 3 immediate-to-register move, 4 register-to-memory move, 5 memory-to-register move, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop. Codes 12 to 15 are unused. `STEP` is the stack-pointer step and defaults to 8.

Top module: `exnpc_unit`

## Requirements
- R1: With opcode 6 and function code 0, 1, 2 or 3, `val_e` is valB+valA, valB−valA, valB AND valA or valB XOR valA respectively, modulo 2^W.
- R2: On a clock edge with opcode 6 and function code 0 to 3, the flags take the following values. Zero is (result == 0). Sign is the result MSB. Overflow is signed overflow of the add or subtract, and 0 for AND and XOR.
- R3: The flags keep their value on any edge where the opcode is not 6, or where the opcode is 6 with a function code of 4 or above. An arithmetic opcode with function code 4 or above gives `val_e` = 0.
- R4: Synchronous active-high reset sets the flags to zero=1, sign=0, overflow=0.
- R5: For opcodes 2 and 7, `cond_ok` applies condition code 0 always, 1 (sign^ovf)|zero, 2 sign^ovf, 3 zero, 4 !zero, 5 !(sign^ovf), 6 !(sign^ovf)&!zero, and 7 to 15 false. `cond_ok` is 0 for every other opcode.
- R6: Opcodes 4 and 5 give `val_e` = valB+valC. Opcode 3 gives `val_e` = valC.
- R7: Opcodes 10 and 8 give `val_e` = valB−STEP. Opcodes 11 and 9 give `val_e` = valB+STEP.
- R8: Opcode 2 gives `val_e` = valA whatever the condition outcome.
- R9: For opcode 7, `new_pc` is valC when `cond_ok` is 1 and valP otherwise.
- R10: `new_pc` is valC for opcode 8, valM for opcode 9, and valP for every opcode other than 7, 8 and 9.
- R11: Opcodes 0, 1, 7 and 12 to 15 give `val_e` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction class |
| ifun | input | 4 | Function or condition code |
| val_a | input | W | Operand A from register read |
| val_b | input | W | Operand B from register read |
| val_c | input | W | Constant word from the instruction |
| val_p | input | W | Fall-through address |
| val_m | input | W | Word read from memory |
| val_e | output | W | ALU result |
| cond_ok | output | 1 | Condition outcome for jumps and conditional moves |
| new_pc | output | W | Next instruction address |

## Verification
The bench builds the unit with W=6 and the default STEP of 8. At that width every pair of operands, under all four arithmetic functions, can be swept in full: 4096 pairs per function. Each result is followed by a read of all condition codes through a jump, so every carry, sign and overflow corner is covered, including the edges of the signed range where overflow flips. A second sweep covers every opcode, every condition code and all 64 values of valB. It runs under five flag states, which reaches both jump outcomes and the wrap of the stack step around zero.

// File: rtl/exnpc_pkg.sv
package exnpc_pkg;

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_NOP   = 4'd1;
    localparam logic [3:0] OP_CMOV  = 4'd2;
    localparam logic [3:0] OP_IRMOV = 4'd3;
    localparam logic [3:0] OP_RMMOV = 4'd4;
    localparam logic [3:0] OP_MRMOV = 4'd5;
    localparam logic [3:0] OP_ALU   = 4'd6;
    localparam logic [3:0] OP_JMP   = 4'd7;
    localparam logic [3:0] OP_CALL  = 4'd8;
    localparam logic [3:0] OP_RET   = 4'd9;
    localparam logic [3:0] OP_PUSH  = 4'd10;
    localparam logic [3:0] OP_POP   = 4'd11;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_t;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_t;

    localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exnpc_alu.sv
module exnpc_alu
    import exnpc_pkg::*;
#(
    parameter int W    = 64,
    parameter int STEP = 8
) (
    input  logic [3:0]   opcode,
    input  logic [3:0]   ifun,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    output logic [W-1:0] val_e,
    output cc_t          cc_new,
    output logic         cc_we
);
    localparam int         MSB    = W - 1;
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] res;
    alu_fn_t      fn;
    logic         ovf;

    // operand and function selection per opcode
    always_comb begin
        opa   = '0;
        opb   = '0;
        fn    = FN_ADD;
        cc_we = 1'b0;
        case (opcode)
            OP_ALU: begin
                if (ifun[3:2] == 2'b00) begin
                    opa   = val_a;
                    opb   = val_b;
                    fn    = alu_fn_t'(ifun[1:0]);
                    cc_we = 1'b1;
                end
            end
            OP_RMMOV, OP_MRMOV: begin
                opa = val_c;
                opb = val_b;
            end
            OP_IRMOV: opa = val_c;
            OP_CMOV:  opa = val_a;
            OP_PUSH, OP_CALL: begin
                opa = STEP_V;
                opb = val_b;
                fn  = FN_SUB;
            end
            OP_POP, OP_RET: begin
                opa = STEP_V;
                opb = val_b;
            end
            default: ;
        endcase
    end

    // datapath
    always_comb begin
        case (fn)
            FN_ADD: begin
                res = opb + opa;
                ovf = (opa[MSB] == opb[MSB]) && (res[MSB] != opb[MSB]);
            end
            FN_SUB: begin
                res = opb - opa;
                ovf = (opa[MSB] != opb[MSB]) && (res[MSB] != opb[MSB]);
            end
            FN_AND: begin
                res = opb & opa;
                ovf = 1'b0;
            end
            default: begin
                res = opb ^ opa;
                ovf = 1'b0;
            end
        endcase
        val_e  = res;
        cc_new = '{zf: (res == '0), sf: res[MSB], of: ovf};
    end

endmodule

// File: rtl/exnpc_flags.sv
module exnpc_flags
    import exnpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cc_t  cc_new,
    output cc_t  cc_q
);
    cc_t cc_d;

    always_comb begin
        cc_d = cc_q;
        if (we) begin
            cc_d = cc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= CC_RESET;
        end else begin
            cc_q <= cc_d;
        end
    end

endmodule

// File: rtl/exnpc_cond.sv
module exnpc_cond
    import exnpc_pkg::*;
(
    input  logic [3:0] opcode,
    input  logic [3:0] ifun,
    input  cc_t        cc,
    output logic       cond_ok
);
    logic lt;
    logic hit;

    always_comb begin
        lt = cc.sf ^ cc.of;
        case (ifun)
            4'd0:    hit = 1'b1;
            4'd1:    hit = lt | cc.zf;
            4'd2:    hit = lt;
            4'd3:    hit = cc.zf;
            4'd4:    hit = !cc.zf;
            4'd5:    hit = !lt;
            4'd6:    hit = !lt && !cc.zf;
            default: hit = 1'b0;
        endcase
        cond_ok = hit && ((opcode == OP_JMP) || (opcode == OP_CMOV));
    end

endmodule

// File: rtl/exnpc_pcsel.sv
module exnpc_pcsel
    import exnpc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   opcode,
    input  logic         cond_ok,
    input  logic [W-1:0] val_c,
    input  logic [W-1:0] val_p,
    input  logic [W-1:0] val_m,
    output logic [W-1:0] new_pc
);
    always_comb begin
        case (opcode)
            OP_JMP:  new_pc = cond_ok ? val_c : val_p;
            OP_CALL: new_pc = val_c;
            OP_RET:  new_pc = val_m;
            default: new_pc = val_p;
        endcase
    end

endmodule

// File: rtl/exnpc_unit.sv
module exnpc_unit
    import exnpc_pkg::*;
#(
    parameter int W    = 64,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   opcode,
    input  logic [3:0]   ifun,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    input  logic [W-1:0] val_p,
    input  logic [W-1:0] val_m,
    output logic [W-1:0] val_e,
    output logic         cond_ok,
    output logic [W-1:0] new_pc
);
    cc_t  cc_new;
    cc_t  cc_q;
    logic cc_we;

    exnpc_alu #(.W(W), .STEP(STEP)) u_alu (
        .opcode (opcode),
        .ifun   (ifun),
        .val_a  (val_a),
        .val_b  (val_b),
        .val_c  (val_c),
        .val_e  (val_e),
        .cc_new (cc_new),
        .cc_we  (cc_we)
    );

    exnpc_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .we     (cc_we),
        .cc_new (cc_new),
        .cc_q   (cc_q)
    );

    exnpc_cond u_cond (
        .opcode  (opcode),
        .ifun    (ifun),
        .cc      (cc_q),
        .cond_ok (cond_ok)
    );

    exnpc_pcsel #(.W(W)) u_pcsel (
        .opcode  (opcode),
        .cond_ok (cond_ok),
        .val_c   (val_c),
        .val_p   (val_p),
        .val_m   (val_m),
        .new_pc  (new_pc)
    );

endmodule

// File: rtl/exnpc_chk.sv
module exnpc_chk
    import exnpc_pkg::*;
#(
    parameter int W    = 64,
    parameter int STEP = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   opcode,
    input logic [3:0]   ifun,
    input logic [W-1:0] val_b,
    input logic [W-1:0] val_c,
    input logic [W-1:0] val_p,
    input logic [W-1:0] val_e,
    input logic         cond_ok,
    input logic [W-1:0] new_pc,
    input cc_t          cc_q
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // R4
    reset_flags_chk: assert property (@(posedge clk) rst |=> (cc_q == CC_RESET));

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !((opcode == OP_ALU) && (ifun[3:2] == 2'b00)) |=> $stable(cc_q));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((opcode == OP_ALU) && (ifun == 4'd0)) |=> (cc_q.zf == ($past(val_e) == '0)));

    // R5
    cond_scope_chk: assert property (@(posedge clk) disable iff (rst)
        cond_ok |-> ((opcode == OP_JMP) || (opcode == OP_CMOV)));

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_POP) |-> (val_e == val_b + STEP_V));

    // R9
    jump_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((opcode == OP_JMP) && !cond_ok) |-> (new_pc == val_p));

    // R10
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_CALL) |-> (new_pc == val_c));

endmodule

bind exnpc_unit exnpc_chk #(.W(W), .STEP(STEP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .ifun    (ifun),
    .val_b   (val_b),
    .val_c   (val_c),
    .val_p   (val_p),
    .val_e   (val_e),
    .cond_ok (cond_ok),
    .new_pc  (new_pc),
    .cc_q    (cc_q)
);

// File: tb/exnpc_unit_tb.sv
module exnpc_unit_tb;
    localparam int W    = 6;
    localparam int STEP = 8;
    localparam int M    = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   opcode = 4'd1;
    logic [3:0]   ifun = 4'd0;
    logic [W-1:0] val_a = '0, val_b = '0, val_c = '0, val_p = '0, val_m = '0;
    logic [W-1:0] val_e;
    logic         cond_ok;
    logic [W-1:0] new_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit mz = 1'b1, ms = 1'b0, mo = 1'b0;

    always #10 clk = ~clk;

    exnpc_unit #(.W(W), .STEP(STEP)) u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .ifun(ifun),
        .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_p(val_p), .val_m(val_m),
        .val_e(val_e), .cond_ok(cond_ok), .new_pc(new_pc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (op %0d fn %0d)", req, act, exp, opcode, ifun);
        end
    endtask

    function automatic bit exp_cond(input int f);
        bit lt = ms ^ mo;
        case (f)
            0: return 1'b1;
            1: return lt | mz;
            2: return lt;
            3: return mz;
            4: return !mz;
            5: return !lt;
            6: return !lt && !mz;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v >= M / 2) ? v - M : v;
    endfunction

    function automatic int exp_e(input int op, input int f, input int a, input int b, input int c);
        case (op)
            6: case (f)
                   0: return (b + a) % M;
                   1: return (b - a + M) % M;
                   2: return b & a;
                   3: return b ^ a;
                   default: return 0;
               endcase
            2: return a;
            3: return c;
            4, 5: return (b + c) % M;
            8, 10: return (b - STEP + 2 * M) % M;
            9, 11: return (b + STEP) % M;
            default: return 0;
        endcase
    endfunction

    task automatic check_conds(input string req);
        opcode = 4'd7;
        for (int f = 0; f < 16; f++) begin
            ifun = f[3:0];
            #1;
            check(cond_ok == exp_cond(f), req, int'(cond_ok), int'(exp_cond(f)));
        end
    endtask

    task automatic alu_step(input int f, input int a, input int b);
        int r, sr;
        @(negedge clk);
        opcode = 4'd6; ifun = f[3:0];
        val_a = a[W-1:0]; val_b = b[W-1:0]; val_p = 6'd33;
        #1;
        r = exp_e(6, f, a, b, 0);
        check(val_e == r[W-1:0], "R1/R3 val_e", int'(val_e), r);
        check(new_pc == 6'd33, "R10 alu pc", int'(new_pc), 33);
        if (f < 4) begin
            mz = (r == 0);
            ms = (r >= M / 2);
            sr = (f == 0) ? sgn(b) + sgn(a) : sgn(b) - sgn(a);
            mo = (f < 2) && (sr >= M / 2 || sr < -(M / 2));
        end
        @(posedge clk);
        #1;
        check_conds(f < 4 ? "R2 flags" : "R3 flags kept");
        opcode = 4'd1;
    endtask

    initial begin
        #(20 * 180000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R4 reset flags visible through jump conditions
        check_conds("R4 reset");

        // R1 R2 exhaustive ALU sweep
        for (int f = 0; f < 4; f++)
            for (int a = 0; a < M; a++)
                for (int b = 0; b < M; b++)
                    alu_step(f, a, b);

        // R3 invalid ALU codes under two flag states
        alu_step(1, 1, 0);
        for (int f = 4; f < 16; f++) alu_step(f, 5, 9);
        alu_step(0, 0, 0);
        for (int f = 4; f < 16; f++) alu_step(f, 63, 63);

        // opcode sweep under several flag states
        for (int s = 0; s < 5; s++) begin
            case (s)
                0: alu_step(0, 0, 0);
                1: alu_step(1, 1, 0);
                2: alu_step(0, 1, 31);
                3: alu_step(0, 1, 1);
                default: alu_step(1, 1, 32);
            endcase
            @(negedge clk);
            for (int op = 0; op < 16; op++) begin
                if (op == 6) continue;
                for (int b = 0; b < M; b++) begin
                    for (int f = 0; f < 8; f++) begin
                        int a, c, p, m, ee, ep;
                        bit ec;
                        a = (b * 5 + 7) % M; c = (b * 3 + 11) % M;
                        p = b ^ 21; m = (b + 17) % M;
                        opcode = op[3:0]; ifun = f[3:0];
                        val_a = a[W-1:0]; val_b = b[W-1:0]; val_c = c[W-1:0];
                        val_p = p[W-1:0]; val_m = m[W-1:0];
                        #1;
                        ec = (op == 2 || op == 7) ? exp_cond(f) : 1'b0;
                        ee = exp_e(op, f, a, b, c);
                        case (op)
                            7: ep = ec ? c : p;
                            8: ep = c;
                            9: ep = m;
                            default: ep = p;
                        endcase
                        check(cond_ok == ec, "R5 cond", int'(cond_ok), int'(ec));
                        if (op == 2) check(val_e == ee[W-1:0], "R8 cmov", int'(val_e), ee);
                        else if (op >= 3 && op <= 5) check(val_e == ee[W-1:0], "R6 addr", int'(val_e), ee);
                        else if (op >= 8 && op <= 11) check(val_e == ee[W-1:0], "R7 stack", int'(val_e), ee);
                        else check(val_e == ee[W-1:0], "R11 zero", int'(val_e), ee);
                        if (op == 7) check(new_pc == ep[W-1:0], "R9 jump", int'(new_pc), ep);
                        else check(new_pc == ep[W-1:0], "R10 pc", int'(new_pc), ep);
                    end
                end
            end
            // R3 non-ALU opcodes across edges left the flags alone
            @(negedge clk);
            check_conds("R3 flags after sweep");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule